// File: doc/BRIEF.md
# Gated-Core Frequency Meter

This block estimates how fast a gated core clock has run on average by comparing it with a fixed reference clock. It has two free-running counters. One advances on every reference tick. The other advances only on cycles where the core clock actually runs. Both counters are always visible as one combined snapshot word.

A one-cycle start request begins a measurement. The controller captures a first snapshot and then counts a programmable number of reference ticks. After that it captures a second snapshot. It forms modulo-2^N differences of both counters, so a counter that wraps between the two captures still gives the true elapsed count.

A sequential divider then turns the two differences into a rate in MHz, and the result is scaled to kHz. The kHz value is presented together with a single-cycle done strobe. Gating and reference activity are modelled as per-cycle tick enables on a single system clock.

Top module: `freq_meter`

## Requirements
- R1: After reset, `done` is 0, `freq_khz` is 0, and both counters (and therefore `snapshot`) are 0.
- R2: The reference counter adds one on every clock edge where `ref_tick` is 1 and wraps modulo 2^CNT_W. It occupies `snapshot[CNT_W-1:0]`.
- R3: The core counter adds one only on edges where `core_tick` is 1 and holds otherwise. It occupies `snapshot[2*CNT_W-1:CNT_W]`.
- R4: A start taken at edge S captures the first snapshot at S. The second snapshot is captured at the first edge after `window_ticks` reference ticks have been registered, counting edges S onward. The window value is latched at S.
- R5: Each delta is the newer count minus the older count, truncated to CNT_W bits, so a wrap between captures yields the exact number of elapsed ticks.
- R6: A core delta of zero makes the result 0.
- R7: A reference delta of zero (idle reference) makes the result 0.
- R8: Otherwise `freq_khz` = floor(core_delta * REF_MHZ / ref_delta) * 1000. The rounding is integer truncation, and the product is formed wide enough that it never overflows.
- R9: `done` is high for exactly one cycle per measurement. `freq_khz` changes only in that cycle and holds until the next completion, including during a later measurement.
- R10: A start request during a measurement in progress is ignored. Completion time and result are those of the original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference clock tick enable for this cycle |
| core_tick | input | 1 | Core clock running in this cycle |
| start | input | 1 | Measurement request pulse |
| window_ticks | input | WIN_W | Window length in reference ticks |
| snapshot | output | 2*CNT_W | {core counter, reference counter} |
| done | output | 1 | One-cycle result strobe |
| freq_khz | output | CNT_W+clog2(REF_MHZ+1)+10 | Estimated core rate in kHz |

## Verification
The bench builds the meter with CNT_W = 10 and keeps REF_MHZ = 408 and WIN_W = 32. With 10-bit counters, the reference counter wraps after 1024 ticks, so a measurement deliberately placed across the wrap point becomes reachable within a short run. The narrower product and quotient also shorten every divide to 19 steps. Ratios below one, above one (reference ticking one cycle in four), and with a fractional part show the truncation rule.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    FM_IDLE,
    FM_WAIT,
    FM_CALC,
    FM_DIV
  } fm_state_e;

  localparam int KHZ_PER_MHZ = 1000;
endpackage

// File: rtl/fm_tick_counter.sv
module fm_tick_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)     count <= '0;
    else if (en) count <= count + W'(1);
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    en |=> count == $past(count) + W'(1));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));
endmodule

// File: rtl/fm_divider.sv
module fm_divider #(
  parameter int NW = 41,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          valid,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);
  localparam int XW = NW + DW;

  logic [DW-1:0] rem, den_q;
  logic [NW-1:0] quo, num_q;
  logic [CW-1:0] left;
  logic          busy;
  logic [DW:0]   trial, next_rem;
  logic          fits;

  always_comb begin
    trial    = {rem, quo[NW-1]};
    fits     = trial >= {1'b0, den_q};
    next_rem = fits ? trial - {1'b0, den_q} : trial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; quo <= '0; den_q <= '0; num_q <= '0;
      left <= '0; busy <= 1'b0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        rem   <= '0;
        quo   <= num;
        num_q <= num;
        den_q <= den;
        left  <= CW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem  <= next_rem[DW-1:0];
        quo  <= {quo[NW-2:0], fits};
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quot = quo;

  logic [XW-1:0] chk_prod, chk_num, chk_den;
  always_comb begin
    chk_prod = XW'(quo) * XW'(den_q);
    chk_num  = XW'(num_q);
    chk_den  = XW'(den_q);
  end

  // quotient is the floor: q*d <= n < (q+1)*d
  a_r8_floor: assert property (@(posedge clk) disable iff (rst)
    valid |-> (chk_prod <= chk_num) && (chk_num - chk_prod < chk_den));
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int WIN_W   = 32,
  parameter int REF_MHZ = 408,
  parameter int PROD_W  = 41,
  parameter int KHZ_W   = 51
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               ref_tick,
  input  logic [WIN_W-1:0]   window_ticks,
  input  logic [2*CNT_W-1:0] snapshot,
  output logic               div_go,
  output logic [PROD_W-1:0]  div_num,
  output logic [CNT_W-1:0]   div_den,
  input  logic               div_valid,
  input  logic [PROD_W-1:0]  div_quot,
  output logic               done,
  output logic [KHZ_W-1:0]   freq_khz
);
  fm_state_e          state;
  logic [2*CNT_W-1:0] snap0, snap1;
  logic [WIN_W-1:0]   win_len, win_cnt;
  logic [CNT_W-1:0]   d_ref, d_core;

  always_comb begin
    d_ref   = snap1[CNT_W-1:0] - snap0[CNT_W-1:0];
    d_core  = snap1[2*CNT_W-1:CNT_W] - snap0[2*CNT_W-1:CNT_W];
    div_num = PROD_W'(d_core) * PROD_W'(REF_MHZ);
    div_den = d_ref;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FM_IDLE; snap0 <= '0; snap1 <= '0;
      win_len <= '0; win_cnt <= '0;
      div_go <= 1'b0; done <= 1'b0; freq_khz <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        FM_IDLE: if (start) begin
          snap0   <= snapshot;
          win_len <= window_ticks;
          win_cnt <= WIN_W'(ref_tick);
          state   <= FM_WAIT;
        end
        FM_WAIT: if (win_cnt >= win_len) begin
          snap1 <= snapshot;
          state <= FM_CALC;
        end else begin
          win_cnt <= win_cnt + WIN_W'(ref_tick);
        end
        FM_CALC: if (d_core == '0 || d_ref == '0) begin
          freq_khz <= '0;
          done     <= 1'b1;
          state    <= FM_IDLE;
        end else begin
          div_go <= 1'b1;
          state  <= FM_DIV;
        end
        default: if (div_valid) begin
          freq_khz <= KHZ_W'(div_quot) * KHZ_W'(KHZ_PER_MHZ);
          done     <= 1'b1;
          state    <= FM_IDLE;
        end
      endcase
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(freq_khz));
  a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
    (state != FM_IDLE && start) |=> $stable(snap0) && $stable(win_len));
  a_r6_zero_result: assert property (@(posedge clk) disable iff (rst)
    (done && (d_core == '0 || d_ref == '0)) |-> freq_khz == '0);
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W   = 32,
  parameter int WIN_W   = 32,
  parameter int REF_MHZ = 408,
  localparam int PROD_W = CNT_W + $clog2(REF_MHZ + 1),
  localparam int KHZ_W  = PROD_W + 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_tick,
  input  logic               core_tick,
  input  logic               start,
  input  logic [WIN_W-1:0]   window_ticks,
  output logic [2*CNT_W-1:0] snapshot,
  output logic               done,
  output logic [KHZ_W-1:0]   freq_khz
);
  logic [1:0]       tick_en;
  logic [CNT_W-1:0] cnt [2];
  logic             div_go, div_valid;
  logic [PROD_W-1:0] div_num, div_quot;
  logic [CNT_W-1:0] div_den;

  assign tick_en = {core_tick, ref_tick};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    fm_tick_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .en(tick_en[g]), .count(cnt[g])
    );
  end

  assign snapshot = {cnt[1], cnt[0]};

  fm_ctrl #(
    .CNT_W(CNT_W), .WIN_W(WIN_W), .REF_MHZ(REF_MHZ),
    .PROD_W(PROD_W), .KHZ_W(KHZ_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ref_tick(ref_tick),
    .window_ticks(window_ticks), .snapshot(snapshot),
    .div_go(div_go), .div_num(div_num), .div_den(div_den),
    .div_valid(div_valid), .div_quot(div_quot),
    .done(done), .freq_khz(freq_khz)
  );

  fm_divider #(.NW(PROD_W), .DW(CNT_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .valid(div_valid), .quot(div_quot)
  );
endmodule

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
  localparam int CNT_W = 10;
  localparam int WIN_W = 32;
  localparam int KHZ_W = CNT_W + 9 + 10;

  logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, core_tick = 1'b0, start = 1'b0;
  logic [WIN_W-1:0]   window_ticks = '0;
  logic [2*CNT_W-1:0] snapshot;
  logic               done;
  logic [KHZ_W-1:0]   freq_khz;

  int vectors = 0, miscompares = 0;
  int rp = 0, cp = 0, ck = 0, ph = 0;
  longint cyc = 0, t0 = 0;

  freq_meter #(.CNT_W(CNT_W), .WIN_W(WIN_W), .REF_MHZ(408)) i_freq_meter (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .core_tick(core_tick),
    .start(start), .window_ticks(window_ticks), .snapshot(snapshot),
    .done(done), .freq_khz(freq_khz)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    ref_tick  <= (rp != 0) && (ph % (rp == 0 ? 1 : rp) == 0);
    core_tick <= (cp != 0) && ((ph % (cp == 0 ? 1 : cp)) < ck);
    ph        <= ph + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model_khz(input longint dc, input longint dr);
    if (dc == 0 || dr == 0) return 0;
    return ((dc * 408) / dr) * 1000;
  endfunction

  task automatic set_mode(input int r, input int c, input int k);
    @(posedge clk);
    rp = r; cp = c; ck = k;
  endtask

  task automatic start_meas(input int win, input bit align);
    @(negedge clk); #1;
    if (align) while (!ref_tick) begin @(negedge clk); #1; end
    window_ticks = win;
    start = 1'b1;
    t0 = cyc;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input longint exp, input string tag, output longint lat);
    int n = 0;
    while (!done && n < 4000) begin @(negedge clk); #1; n++; end
    lat = cyc - t0;
    check(done === 1'b1, {tag, " done seen"}, done, 1);
    check(freq_khz == exp, tag, freq_khz, exp);
    @(negedge clk); #1;
    check(done === 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    check(done === 1'b0, "R1 done", done, 0);
    check(freq_khz == 0, "R1 freq", freq_khz, 0);
    check(snapshot == 0, "R1 snapshot", snapshot, 0);
  endtask

  task automatic t_counters();
    set_mode(1, 0, 0);
    repeat (5) @(posedge clk);
    rp = 0; cp = 1; ck = 1;
    repeat (3) @(posedge clk);
    cp = 0; ck = 0;
    repeat (2) @(negedge clk); #1;
    check(snapshot[CNT_W-1:0] == 5, "R2 reference field", snapshot[CNT_W-1:0], 5);
    check(snapshot[2*CNT_W-1:CNT_W] == 3, "R3 core field", snapshot[2*CNT_W-1:CNT_W], 3);
  endtask

  task automatic t_ratio(input int c, input int k, input int win, input string tag);
    longint lat;
    set_mode(1, c, k);
    start_meas(win, 1'b0);
    wait_done(model_khz(longint'(win) * k / c, win), tag, lat);
  endtask

  task automatic t_slow_ref();
    longint lat;
    set_mode(4, 1, 1);
    start_meas(50, 1'b1);
    wait_done(model_khz(197, 50), "R4 R8 slow reference", lat);
  endtask

  task automatic t_core_gated();
    longint lat;
    set_mode(1, 0, 0);
    start_meas(50, 1'b0);
    wait_done(0, "R6 core delta zero", lat);
  endtask

  task automatic t_ref_idle();
    longint lat;
    set_mode(0, 1, 1);
    start_meas(0, 1'b0);
    wait_done(0, "R7 reference delta zero", lat);
  endtask

  task automatic t_wrap();
    longint lat;
    int n = 0;
    set_mode(1, 2, 1);
    @(negedge clk); #1;
    while (!(snapshot[CNT_W-1:0] >= 900 && snapshot[CNT_W-1:0] <= 910) && n < 3000) begin
      @(negedge clk); #1; n++;
    end
    start_meas(200, 1'b0);
    wait_done(model_khz(100, 200), "R5 wrap across measurement", lat);
  endtask

  task automatic t_hold();
    longint lat;
    t_ratio(1, 1, 60, "R9 setup full rate");
    set_mode(1, 0, 0);
    start_meas(100, 1'b0);
    repeat (40) @(negedge clk); #1;
    check(freq_khz == 408000, "R9 result held mid-run", freq_khz, 408000);
    check(done === 1'b0, "R9 no strobe mid-run", done, 0);
    wait_done(0, "R9 new result replaces", lat);
  endtask

  task automatic t_busy_start();
    longint base, lat;
    set_mode(1, 1, 1);
    start_meas(100, 1'b0);
    wait_done(408000, "R10 baseline", base);
    start_meas(100, 1'b0);
    repeat (30) @(negedge clk); #1;
    window_ticks = 3;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    wait_done(408000, "R10 result unchanged", lat);
    check(lat == base, "R10 completion time unchanged", lat, base);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_counters();
    t_ratio(1, 1, 200, "R8 full rate");
    t_ratio(2, 1, 200, "R8 half rate");
    t_ratio(4, 3, 200, "R8 three quarters");
    t_ratio(5, 1, 200, "R8 truncation");
    t_slow_ref();
    t_core_gated();
    t_ref_idle();
    t_wrap();
    t_hold();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule